// File: doc/BRIEF.md
# Single-Cycle Control Decoder

This block is the control unit of a single-cycle core with separate instruction and data memories. It contains no state. From the 6-bit primary opcode, the 6-bit function field and the zero flag returned by the ALU, it produces every select and write enable the datapath needs in one cycle. These controls cover immediate extension, the ALU B-operand source, the ALU operation, the data-memory write, the register-file write, the write-back source, the destination register and the next-PC source.

Conditional branches are resolved inside the decoder. The zero flag picks the taken or the fall-through PC directly, so the datapath needs no separate branch comparator. Link instructions write the return address through a PC write-back source, and their destination is forced to register 31. Any opcode or function value that is not listed below counts as illegal. An illegal instruction performs no write and falls through to pc+4.

Output encodings: ext_sel 0 = sign-extend 16, 1 = zero-extend 16, 2 = imm in upper half. b_src 0 = register, 1 = immediate. wb_src 0 = ALU, 1 = memory, 2 = PC. reg_dst 0 = rt, 1 = rd, 2 = r31. pc_src 0 = pc+4, 1 = branch target, 2 = register-indirect, 3 = absolute jump. op_sel values: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 slt, 7 sltu, 8 pass-B, 9 zero-test. Any field not named in a requirement takes value 0.

Top module: `ctl_decoder`

## Requirements
- R1: When opcode is 0x00 and funct is one of 0x20/0x21 (add), 0x22/0x23 (sub), 0x24 (and), 0x25 (or), 0x26 (xor), 0x27 (nor), 0x2A (slt) or 0x2B (sltu), the outputs are b_src=0, op_sel from funct, reg_we=1, wb_src=0, reg_dst=1 and pc_src=0.
- R2: Opcodes 0x08/0x09 (add), 0x0A (slt) and 0x0B (sltu) give ext_sel=0, b_src=1, op_sel from opcode, reg_we=1, wb_src=0, reg_dst=0 and pc_src=0.
- R3: Opcodes 0x0C (and), 0x0D (or) and 0x0E (xor) give the same outputs as R2, except that ext_sel=1.
- R4: Opcode 0x0F gives ext_sel=2, b_src=1, op_sel=8 (pass-B), reg_we=1 and reg_dst=0.
- R5: Opcode 0x23 (load word) gives ext_sel=0, b_src=1, op_sel=0, reg_we=1, wb_src=1 and reg_dst=0.
- R6: Opcode 0x2B (store word) gives ext_sel=0, b_src=1, op_sel=0, mem_we=1 and reg_we=0.
- R7: Opcodes 0x04 (branch if zero) and 0x05 (branch if nonzero) give op_sel=9 and no writes. pc_src is 1 when the condition holds on zero and 0 otherwise.
- R8: Opcode 0x02 gives pc_src=3, and opcode 0x00 with funct 0x08 gives pc_src=2. Neither writes anything.
- R9: Opcode 0x03 (pc_src=3), and opcode 0x00 with funct 0x09 (pc_src=2), also give reg_we=1, wb_src=2 and reg_dst=2.
- R10: Any other opcode, or opcode 0x00 with any other funct, drives every output to 0: no writes and pc_src=0.
- R11: When opcode is nonzero, funct has no effect on any output.
- R12: The zero flag affects only pc_src, and only for opcodes 0x04 and 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field (used when opcode is 0) |
| zero | input | 1 | ALU result-is-zero flag |
| ext_sel | output | 2 | Immediate extension mode |
| b_src | output | 1 | ALU B-operand source |
| op_sel | output | 4 | ALU operation |
| mem_we | output | 1 | Data memory write enable |
| reg_we | output | 1 | Register file write enable |
| wb_src | output | 2 | Write-back source |
| reg_dst | output | 2 | Destination register select |
| pc_src | output | 2 | Next-PC source |

## Verification
The decoder is driven with every combination of opcode, funct and zero flag, 8192 patterns in all. Each pattern is compared field by field against a behavioural table kept in the bench. Sweeping funct under nonzero opcodes shows that the function field is ignored. Sweeping it under opcode 0 separates the register-register, register-jump and illegal codes. Toggling zero under every opcode shows that only the two branches react to it, and in opposite senses.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int OPS_W = 4;
  localparam int SEL_W = 2;

  typedef enum logic [3:0] {
    CL_ILLEGAL, CL_RR, CL_IMM_S, CL_IMM_U, CL_IMM_HI, CL_LOAD, CL_STORE,
    CL_BR_Z, CL_BR_NZ, CL_JABS, CL_JABS_LINK, CL_JREG, CL_JREG_LINK
  } iclass_e;

  // primary opcodes
  localparam logic [OPC_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OP_J       = 6'h02;
  localparam logic [OPC_W-1:0] OP_JAL     = 6'h03;
  localparam logic [OPC_W-1:0] OP_BEQZ    = 6'h04;
  localparam logic [OPC_W-1:0] OP_BNEZ    = 6'h05;
  localparam logic [OPC_W-1:0] OP_ADDI    = 6'h08;
  localparam logic [OPC_W-1:0] OP_ADDIU   = 6'h09;
  localparam logic [OPC_W-1:0] OP_SLTI    = 6'h0A;
  localparam logic [OPC_W-1:0] OP_SLTIU   = 6'h0B;
  localparam logic [OPC_W-1:0] OP_ANDI    = 6'h0C;
  localparam logic [OPC_W-1:0] OP_ORI     = 6'h0D;
  localparam logic [OPC_W-1:0] OP_XORI    = 6'h0E;
  localparam logic [OPC_W-1:0] OP_LUI     = 6'h0F;
  localparam logic [OPC_W-1:0] OP_LW      = 6'h23;
  localparam logic [OPC_W-1:0] OP_SW      = 6'h2B;

  // function codes under OP_SPECIAL
  localparam logic [FN_W-1:0] FN_JR   = 6'h08;
  localparam logic [FN_W-1:0] FN_JALR = 6'h09;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  // ALU operation codes
  localparam logic [OPS_W-1:0] ALU_ADD   = 4'd0;
  localparam logic [OPS_W-1:0] ALU_SUB   = 4'd1;
  localparam logic [OPS_W-1:0] ALU_AND   = 4'd2;
  localparam logic [OPS_W-1:0] ALU_OR    = 4'd3;
  localparam logic [OPS_W-1:0] ALU_XOR   = 4'd4;
  localparam logic [OPS_W-1:0] ALU_NOR   = 4'd5;
  localparam logic [OPS_W-1:0] ALU_SLT   = 4'd6;
  localparam logic [OPS_W-1:0] ALU_SLTU  = 4'd7;
  localparam logic [OPS_W-1:0] ALU_PASSB = 4'd8;
  localparam logic [OPS_W-1:0] ALU_ZTST  = 4'd9;

  // select encodings
  localparam logic [SEL_W-1:0] EXT_SIGN = 2'd0;
  localparam logic [SEL_W-1:0] EXT_ZERO = 2'd1;
  localparam logic [SEL_W-1:0] EXT_HIGH = 2'd2;
  localparam logic             BS_REG   = 1'b0;
  localparam logic             BS_IMM   = 1'b1;
  localparam logic [SEL_W-1:0] WB_ALU   = 2'd0;
  localparam logic [SEL_W-1:0] WB_MEM   = 2'd1;
  localparam logic [SEL_W-1:0] WB_PC    = 2'd2;
  localparam logic [SEL_W-1:0] DST_RT   = 2'd0;
  localparam logic [SEL_W-1:0] DST_RD   = 2'd1;
  localparam logic [SEL_W-1:0] DST_R31  = 2'd2;
  localparam logic [SEL_W-1:0] PC_SEQ   = 2'd0;
  localparam logic [SEL_W-1:0] PC_BR    = 2'd1;
  localparam logic [SEL_W-1:0] PC_RIND  = 2'd2;
  localparam logic [SEL_W-1:0] PC_JABS  = 2'd3;

  // {valid, op}: ALU operation named by a function code
  function automatic logic [OPS_W:0] alu_of_funct(input logic [FN_W-1:0] fn);
    logic [OPS_W:0] r;
    unique case (fn)
      FN_ADD, FN_ADDU: r = {1'b1, ALU_ADD};
      FN_SUB, FN_SUBU: r = {1'b1, ALU_SUB};
      FN_AND:          r = {1'b1, ALU_AND};
      FN_OR:           r = {1'b1, ALU_OR};
      FN_XOR:          r = {1'b1, ALU_XOR};
      FN_NOR:          r = {1'b1, ALU_NOR};
      FN_SLT:          r = {1'b1, ALU_SLT};
      FN_SLTU:         r = {1'b1, ALU_SLTU};
      default:         r = {1'b0, ALU_ADD};
    endcase
    return r;
  endfunction

  // ALU operation named by an immediate-form opcode
  function automatic logic [OPS_W-1:0] alu_of_opcode(input logic [OPC_W-1:0] op);
    logic [OPS_W-1:0] r;
    unique case (op)
      OP_SLTI:  r = ALU_SLT;
      OP_SLTIU: r = ALU_SLTU;
      OP_ANDI:  r = ALU_AND;
      OP_ORI:   r = ALU_OR;
      OP_XORI:  r = ALU_XOR;
      OP_LUI:   r = ALU_PASSB;
      default:  r = ALU_ADD;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ctl_class_decode.sv
module ctl_class_decode
  import ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output iclass_e          iclass
);
  logic [OPS_W:0] fn_alu;
  assign fn_alu = alu_of_funct(funct);

  always_comb begin
    unique case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JR)        iclass = CL_JREG;
        else if (funct == FN_JALR) iclass = CL_JREG_LINK;
        else if (fn_alu[OPS_W])    iclass = CL_RR;
        else                       iclass = CL_ILLEGAL;
      end
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: iclass = CL_IMM_S;
      OP_ANDI, OP_ORI, OP_XORI:             iclass = CL_IMM_U;
      OP_LUI:  iclass = CL_IMM_HI;
      OP_LW:   iclass = CL_LOAD;
      OP_SW:   iclass = CL_STORE;
      OP_BEQZ: iclass = CL_BR_Z;
      OP_BNEZ: iclass = CL_BR_NZ;
      OP_J:    iclass = CL_JABS;
      OP_JAL:  iclass = CL_JABS_LINK;
      default: iclass = CL_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/ctl_alu_select.sv
module ctl_alu_select
  import ctl_pkg::*;
(
  input  iclass_e          iclass,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [OPS_W-1:0] op_sel
);
  logic [OPS_W:0]   fn_alu;
  logic [OPS_W-1:0] op_alu;
  assign fn_alu = alu_of_funct(funct);
  assign op_alu = alu_of_opcode(opcode);

  always_comb begin
    unique case (iclass)
      CL_RR:                                  op_sel = fn_alu[OPS_W-1:0];
      CL_IMM_S, CL_IMM_U, CL_IMM_HI:          op_sel = op_alu;
      CL_BR_Z, CL_BR_NZ:                      op_sel = ALU_ZTST;
      default:                                op_sel = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/ctl_route_decode.sv
module ctl_route_decode
  import ctl_pkg::*;
(
  input  iclass_e          iclass,
  input  logic             zero,
  output logic [SEL_W-1:0] ext_sel,
  output logic             b_src,
  output logic             mem_we,
  output logic             reg_we,
  output logic [SEL_W-1:0] wb_src,
  output logic [SEL_W-1:0] reg_dst,
  output logic [SEL_W-1:0] pc_src,
  output logic             br_taken
);
  // branch condition resolved here from the zero flag
  always_comb begin
    unique case (iclass)
      CL_BR_Z:  br_taken = zero;
      CL_BR_NZ: br_taken = !zero;
      default:  br_taken = 1'b0;
    endcase
  end

  always_comb begin
    ext_sel = EXT_SIGN;
    b_src   = BS_REG;
    mem_we  = 1'b0;
    reg_we  = 1'b0;
    wb_src  = WB_ALU;
    reg_dst = DST_RT;
    pc_src  = PC_SEQ;
    unique case (iclass)
      CL_RR: begin
        reg_we = 1'b1; reg_dst = DST_RD;
      end
      CL_IMM_S: begin
        b_src = BS_IMM; reg_we = 1'b1;
      end
      CL_IMM_U: begin
        ext_sel = EXT_ZERO; b_src = BS_IMM; reg_we = 1'b1;
      end
      CL_IMM_HI: begin
        ext_sel = EXT_HIGH; b_src = BS_IMM; reg_we = 1'b1;
      end
      CL_LOAD: begin
        b_src = BS_IMM; reg_we = 1'b1; wb_src = WB_MEM;
      end
      CL_STORE: begin
        b_src = BS_IMM; mem_we = 1'b1;
      end
      CL_BR_Z, CL_BR_NZ: begin
        pc_src = br_taken ? PC_BR : PC_SEQ;
      end
      CL_JABS:  pc_src = PC_JABS;
      CL_JREG:  pc_src = PC_RIND;
      CL_JABS_LINK: begin
        pc_src = PC_JABS; reg_we = 1'b1; wb_src = WB_PC; reg_dst = DST_R31;
      end
      CL_JREG_LINK: begin
        pc_src = PC_RIND; reg_we = 1'b1; wb_src = WB_PC; reg_dst = DST_R31;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       zero,
  output logic [1:0] ext_sel,
  output logic       b_src,
  output logic [3:0] op_sel,
  output logic       mem_we,
  output logic       reg_we,
  output logic [1:0] wb_src,
  output logic [1:0] reg_dst,
  output logic [1:0] pc_src
);
  iclass_e iclass;
  logic    br_taken;

  ctl_class_decode u_class (
    .opcode (opcode),
    .funct  (funct),
    .iclass (iclass)
  );

  ctl_alu_select u_alu (
    .iclass (iclass),
    .opcode (opcode),
    .funct  (funct),
    .op_sel (op_sel)
  );

  ctl_route_decode u_route (
    .iclass   (iclass),
    .zero     (zero),
    .ext_sel  (ext_sel),
    .b_src    (b_src),
    .mem_we   (mem_we),
    .reg_we   (reg_we),
    .wb_src   (wb_src),
    .reg_dst  (reg_dst),
    .pc_src   (pc_src),
    .br_taken (br_taken)
  );

  always_comb begin
    // R6
    no_dual_write_chk: assert (!(mem_we && reg_we))
      else $error("memory and register writes both enabled");
    // R9
    link_dest_chk: assert (wb_src != WB_PC || (reg_we && reg_dst == DST_R31))
      else $error("PC write-back without r31 write");
    // R7
    branch_op_chk: assert (pc_src != PC_BR || (op_sel == ALU_ZTST && !reg_we && !mem_we))
      else $error("branch target taken without zero-test");
    // R10
    illegal_safe_chk: assert (iclass != CL_ILLEGAL || (!reg_we && !mem_we && pc_src == PC_SEQ))
      else $error("illegal instruction produced a side effect");
    // R5
    load_path_chk: assert (wb_src != WB_MEM || (reg_we && b_src == BS_IMM && op_sel == ALU_ADD))
      else $error("memory write-back without load addressing");
    // R12
    taken_class_chk: assert (!br_taken || iclass == CL_BR_Z || iclass == CL_BR_NZ)
      else $error("branch taken outside a branch class");
  end
endmodule

// File: tb/tb_ctl_decoder.sv
module tb_ctl_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [5:0] opcode, funct;
  logic       zero;
  logic [1:0] ext_sel, wb_src, reg_dst, pc_src;
  logic       b_src, mem_we, reg_we;
  logic [3:0] op_sel;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  ctl_decoder dut (
    .opcode(opcode), .funct(funct), .zero(zero),
    .ext_sel(ext_sel), .b_src(b_src), .op_sel(op_sel), .mem_we(mem_we),
    .reg_we(reg_we), .wb_src(wb_src), .reg_dst(reg_dst), .pc_src(pc_src)
  );

  // expected fields, filled by the reference table
  int e_ext, e_bs, e_ops, e_mw, e_rw, e_wb, e_dst, e_pc;
  string tag;

  task automatic reference(input int op, input int fn, input int z);
    e_ext = 0; e_bs = 0; e_ops = 0; e_mw = 0; e_rw = 0; e_wb = 0; e_dst = 0; e_pc = 0;
    tag = "R10";
    if (op == 0) begin
      case (fn)
        'h20, 'h21: begin tag = "R1"; e_ops = 0; end
        'h22, 'h23: begin tag = "R1"; e_ops = 1; end
        'h24: begin tag = "R1"; e_ops = 2; end
        'h25: begin tag = "R1"; e_ops = 3; end
        'h26: begin tag = "R1"; e_ops = 4; end
        'h27: begin tag = "R1"; e_ops = 5; end
        'h2A: begin tag = "R1"; e_ops = 6; end
        'h2B: begin tag = "R1"; e_ops = 7; end
        'h08: begin tag = "R8"; e_pc = 2; end
        'h09: begin tag = "R9"; e_pc = 2; e_rw = 1; e_wb = 2; e_dst = 2; end
        default: tag = "R10";
      endcase
      if (tag == "R1") begin e_rw = 1; e_dst = 1; end
    end else begin
      case (op)
        'h08, 'h09: begin tag = "R2"; e_ops = 0; end
        'h0A: begin tag = "R2"; e_ops = 6; end
        'h0B: begin tag = "R2"; e_ops = 7; end
        'h0C: begin tag = "R3"; e_ops = 2; e_ext = 1; end
        'h0D: begin tag = "R3"; e_ops = 3; e_ext = 1; end
        'h0E: begin tag = "R3"; e_ops = 4; e_ext = 1; end
        'h0F: begin tag = "R4"; e_ops = 8; e_ext = 2; end
        'h23: begin tag = "R5"; e_bs = 1; e_rw = 1; e_wb = 1; end
        'h2B: begin tag = "R6"; e_bs = 1; e_mw = 1; end
        'h04: begin tag = "R7"; e_ops = 9; e_pc = (z != 0) ? 1 : 0; end
        'h05: begin tag = "R7"; e_ops = 9; e_pc = (z == 0) ? 1 : 0; end
        'h02: begin tag = "R8"; e_pc = 3; end
        'h03: begin tag = "R9"; e_pc = 3; e_rw = 1; e_wb = 2; e_dst = 2; end
        default: tag = "R10";
      endcase
      if (tag == "R2" || tag == "R3" || tag == "R4") begin e_bs = 1; e_rw = 1; end
      if (fn != 0) tag = {tag, "+R11"};
    end
    if (z != 0 && op != 'h04 && op != 'h05) tag = {tag, "+R12"};
  endtask

  task automatic field(input string name, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      bad = 1'b1;
      $display("FAIL %s op=%02h fn=%02h z=%0d %s actual=%0d expected=%0d",
               tag, opcode, funct, zero, name, act, exp);
    end
  endtask

  initial begin
    opcode = 6'd0; funct = 6'd0; zero = 1'b0;
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        for (int z = 0; z < 2; z++) begin
          @(posedge clk);
          opcode = 6'(op); funct = 6'(fn); zero = (z != 0);
          @(negedge clk);
          reference(op, fn, z);
          begin
            bit bad = 1'b0;
            field("ext_sel", int'(ext_sel), e_ext, bad);
            field("b_src",   int'(b_src),   e_bs,  bad);
            field("op_sel",  int'(op_sel),  e_ops, bad);
            field("mem_we",  int'(mem_we),  e_mw,  bad);
            field("reg_we",  int'(reg_we),  e_rw,  bad);
            field("wb_src",  int'(wb_src),  e_wb,  bad);
            field("reg_dst", int'(reg_dst), e_dst, bad);
            field("pc_src",  int'(pc_src),  e_pc,  bad);
            compared++;
            if (bad) mismatched++;
          end
        end
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule